// File: doc/BRIEF.md
# Raster Position and Event Generator

This block walks a video raster one pixel per enabled clock, using programmable horizontal and vertical totals together with blanking and sync positions. From that walk it keeps three counters: a scanline count, a pixel count that runs across the whole frame, and a frame count. It also produces single-cycle strobes for vertical-blank start, frame start and vertical-sync start, plus a strobe that tells the rest of the display pipe to latch its double-buffered registers.

The positions of the events follow horizontal sync rather than the start of the line. The vertical-blank, vertical-sync and latch strobes fire at the horizontal-sync position of the line before the line they name. The scanline counter also steps at horizontal sync, so at the start of a line it still holds the previous line's number. The frame counter and the pixel counter roll over together at the first active pixel of line 0.

The timing inputs are shadow values. They are copied into the active set once, in the first clock after reset, and after that only in the cycle of the latch strobe. A write in mid-frame therefore leaves the frame in progress unchanged.

Top module: `raster_timing`

## Requirements
- R1: While reset is low, every counter, the vertical-blank level and every strobe read 0. In the first clock after reset the timing inputs are loaded and the position stays at line 0, pixel 0. After that clock the scanline reads vtotal-1 and no strobe is high.
- R2: The raster advances one pixel on each clock with the pixel enable high and holds when it is low. A frame lasts htotal*vtotal enabled clocks.
- R3: The pixel counter reads line*htotal + pixel, where line 0 pixel 0 is the first active pixel, where it reads 0. At pixel 0 of line vblank_start it reads vblank_start*htotal.
- R4: The frame counter (FRAME_W bits, default 24) increments on the enabled clock that returns the pixel counter to 0, and it wraps from all ones to 0.
- R5: At the horizontal-sync position of line n, the scanline counter takes the value n. It holds that value until the next line's sync, so at pixel 0 of line 0 it reads vtotal-1.
- R6: The vertical-blank-start strobe and the latch strobe are high together for one clock at the horizontal-sync position of line vblank_start-1, or of line vtotal-1 when vblank_start is 0.
- R7: The vertical-sync-start strobe is high for one clock at the horizontal-sync position of line vsync_start-1, or of line vtotal-1 when vsync_start is 0.
- R8: The frame-start strobe is high for one clock at the horizontal-blank position (which must lie below hsync_start) of line (vblank_start + delay) mod vtotal. The delay is the 2-bit input, 0 to 3, so the strobe comes 1 to 4 lines after the line that carries the vertical-blank strobe.
- R9: The vertical-blank level is high from pixel 0 of each line n with vblank_start <= n < vblank_end, and low on every other line.
- R10: A change to the timing inputs has no effect until the clock in which the latch strobe is high. From that clock on, the rest of the frame and the following frames use the new values.
- R11: Each strobe is high for exactly one clock per event, even when the pixel enable stays low after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_en_i | input | 1 | Pixel enable: one raster step per clock while high |
| cfg_htotal_i | input | H_W | Shadow pixels per line |
| cfg_hblank_i | input | H_W | Shadow horizontal-blank start position |
| cfg_hsync_i | input | H_W | Shadow horizontal-sync start position |
| cfg_vtotal_i | input | V_W | Shadow lines per frame |
| cfg_vblank_i | input | V_W | Shadow first vertical-blank line |
| cfg_vsync_i | input | V_W | Shadow first vertical-sync line |
| cfg_vblank_end_i | input | V_W | Shadow first line after vertical blank |
| cfg_fs_delay_i | input | 2 | Shadow frame-start delay, 0 to 3 |
| scanline_o | output | V_W | Scanline counter |
| pixel_count_o | output | H_W+V_W | Pixel counter within the frame |
| frame_count_o | output | FRAME_W | Frame counter |
| in_vblank_o | output | 1 | Vertical-blank level |
| vblank_start_o | output | 1 | Vertical-blank-start strobe |
| frame_start_o | output | 1 | Frame-start strobe |
| vsync_start_o | output | 1 | Vertical-sync-start strobe |
| latch_o | output | 1 | Double-buffer latch strobe |

## Verification
A horizontal position that is off by one shows up on the very next enabled clock as a pixel count one away from line*htotal + pixel. It also moves every strobe by a clock, so the bench compares all outputs on every clock of a whole frame and catches the fault at the first event position. A line counter that wraps at the wrong place, or that uses timing it has not yet latched, changes the frame length. That shows up at the first frame roll-over as a wrong frame count or a non-zero pixel count. A scanline register that steps at the line start rather than at sync is wrong on the first clock of every line.

// File: rtl/raster_pkg.sv
package raster_pkg;

    // Bit positions of the event strobes inside the event vector
    typedef enum logic [1:0] {
        EV_VBLANK = 2'd0,
        EV_LATCH  = 2'd1,
        EV_FSTART = 2'd2,
        EV_VSYNC  = 2'd3
    } ev_e;

    localparam int unsigned EV_NUM = 4;

endpackage

// File: rtl/raster_shadow.sv
// Active timing bank: loaded once after reset and again on every latch strobe.
module raster_shadow #(
    parameter int unsigned H_W = 12,
    parameter int unsigned V_W = 12
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           latch_i,
    input  logic [H_W-1:0] cfg_htotal_i,
    input  logic [H_W-1:0] cfg_hblank_i,
    input  logic [H_W-1:0] cfg_hsync_i,
    input  logic [V_W-1:0] cfg_vtotal_i,
    input  logic [V_W-1:0] cfg_vblank_i,
    input  logic [V_W-1:0] cfg_vsync_i,
    input  logic [V_W-1:0] cfg_vblank_end_i,
    input  logic [1:0]     cfg_fs_delay_i,
    output logic           boot_o,
    output logic [H_W-1:0] htotal_o,
    output logic [H_W-1:0] hblank_o,
    output logic [H_W-1:0] hsync_o,
    output logic [V_W-1:0] vtotal_o,
    output logic [V_W-1:0] vblank_o,
    output logic [V_W-1:0] vsync_o,
    output logic [V_W-1:0] vblank_end_o,
    output logic [1:0]     fs_delay_o
);

    typedef struct packed {
        logic           boot;
        logic [H_W-1:0] htotal;
        logic [H_W-1:0] hblank;
        logic [H_W-1:0] hsync;
        logic [V_W-1:0] vtotal;
        logic [V_W-1:0] vblank;
        logic [V_W-1:0] vsync;
        logic [V_W-1:0] vblank_end;
        logic [1:0]     fs_delay;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d      = bank_q;
        bank_d.boot = 1'b0;
        if (bank_q.boot || latch_i) begin
            bank_d.htotal     = cfg_htotal_i;
            bank_d.hblank     = cfg_hblank_i;
            bank_d.hsync      = cfg_hsync_i;
            bank_d.vtotal     = cfg_vtotal_i;
            bank_d.vblank     = cfg_vblank_i;
            bank_d.vsync      = cfg_vsync_i;
            bank_d.vblank_end = cfg_vblank_end_i;
            bank_d.fs_delay   = cfg_fs_delay_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            bank_q      <= '0;
            bank_q.boot <= 1'b1;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign boot_o       = bank_q.boot;
    assign htotal_o     = bank_q.htotal;
    assign hblank_o     = bank_q.hblank;
    assign hsync_o      = bank_q.hsync;
    assign vtotal_o     = bank_q.vtotal;
    assign vblank_o     = bank_q.vblank;
    assign vsync_o      = bank_q.vsync;
    assign vblank_end_o = bank_q.vblank_end;
    assign fs_delay_o   = bank_q.fs_delay;

endmodule

// File: rtl/raster_position.sv
// Horizontal / vertical raster walker; exposes both current and next position.
module raster_position #(
    parameter int unsigned H_W = 12,
    parameter int unsigned V_W = 12
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           step_i,
    input  logic [H_W-1:0] htotal_i,
    input  logic [V_W-1:0] vtotal_i,
    output logic [H_W-1:0] h_o,
    output logic [V_W-1:0] v_o,
    output logic [H_W-1:0] h_next_o,
    output logic [V_W-1:0] v_next_o
);

    typedef struct packed {
        logic [H_W-1:0] h;
        logic [V_W-1:0] v;
    } pos_t;

    pos_t pos_d, pos_q;

    always_comb begin
        pos_d = pos_q;
        if (step_i) begin
            // ">=" keeps the walk bounded if a smaller total is latched mid-line
            if (pos_q.h >= htotal_i - H_W'(1)) begin
                pos_d.h = '0;
                if (pos_q.v >= vtotal_i - V_W'(1)) begin
                    pos_d.v = '0;
                end else begin
                    pos_d.v = pos_q.v + V_W'(1);
                end
            end else begin
                pos_d.h = pos_q.h + H_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_d;
        end
    end

    assign h_o      = pos_q.h;
    assign v_o      = pos_q.v;
    assign h_next_o = pos_d.h;
    assign v_next_o = pos_d.v;

endmodule

// File: rtl/raster_events.sv
// Decodes the next raster position into registered single-cycle event strobes.
module raster_events
    import raster_pkg::*;
#(
    parameter int unsigned H_W = 12,
    parameter int unsigned V_W = 12
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              step_i,
    input  logic [H_W-1:0]    h_next_i,
    input  logic [V_W-1:0]    v_next_i,
    input  logic [H_W-1:0]    hblank_i,
    input  logic [H_W-1:0]    hsync_i,
    input  logic [V_W-1:0]    vtotal_i,
    input  logic [V_W-1:0]    vblank_i,
    input  logic [V_W-1:0]    vsync_i,
    input  logic [1:0]        fs_delay_i,
    output logic [EV_NUM-1:0] ev_o,
    output logic              latch_next_o
);

    typedef struct packed {
        logic [EV_NUM-1:0] ev;
    } evr_t;

    evr_t evr_d, evr_q;

    logic [V_W-1:0]    vb_line, vs_line, fs_line;
    logic [V_W:0]      fs_sum;
    logic [EV_NUM-1:0] hit;

    always_comb begin
        // line that carries the sync-aligned strobe: one before the named line
        vb_line = (vblank_i == '0) ? vtotal_i - V_W'(1) : vblank_i - V_W'(1);
        vs_line = (vsync_i  == '0) ? vtotal_i - V_W'(1) : vsync_i  - V_W'(1);
        fs_sum  = {1'b0, vblank_i} + (V_W+1)'(fs_delay_i);
        if (fs_sum >= {1'b0, vtotal_i}) begin
            fs_line = V_W'(fs_sum - {1'b0, vtotal_i});
        end else begin
            fs_line = fs_sum[V_W-1:0];
        end

        hit            = '0;
        hit[EV_VBLANK] = (h_next_i == hsync_i)  && (v_next_i == vb_line);
        hit[EV_LATCH]  = (h_next_i == hsync_i)  && (v_next_i == vb_line);
        hit[EV_FSTART] = (h_next_i == hblank_i) && (v_next_i == fs_line);
        hit[EV_VSYNC]  = (h_next_i == hsync_i)  && (v_next_i == vs_line);

        evr_d = evr_q;
        for (int i = 0; i < EV_NUM; i++) begin
            evr_d.ev[i] = step_i && hit[i];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            evr_q <= '0;
        end else begin
            evr_q <= evr_d;
        end
    end

    assign ev_o         = evr_q.ev;
    assign latch_next_o = evr_d.ev[EV_LATCH];

endmodule

// File: rtl/raster_counters.sv
// Scanline, pixel-in-frame and frame counters plus the vertical-blank level.
module raster_counters #(
    parameter int unsigned H_W     = 12,
    parameter int unsigned V_W     = 12,
    parameter int unsigned PIX_W   = 24,
    parameter int unsigned FRAME_W = 24
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               step_i,
    input  logic               init_i,
    input  logic [V_W-1:0]     init_line_i,
    input  logic [H_W-1:0]     h_next_i,
    input  logic [V_W-1:0]     v_next_i,
    input  logic [H_W-1:0]     hsync_i,
    input  logic [V_W-1:0]     vblank_i,
    input  logic [V_W-1:0]     vblank_end_i,
    output logic [V_W-1:0]     scanline_o,
    output logic [PIX_W-1:0]   pixel_o,
    output logic [FRAME_W-1:0] frame_o,
    output logic               in_vblank_o
);

    typedef struct packed {
        logic [V_W-1:0]     line;
        logic [PIX_W-1:0]   pix;
        logic [FRAME_W-1:0] frame;
        logic               vb;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic at_origin;

    always_comb begin
        cnt_d     = cnt_q;
        at_origin = (h_next_i == '0) && (v_next_i == '0);
        if (init_i) begin
            cnt_d.line = init_line_i;
        end else if (step_i) begin
            if (h_next_i == hsync_i) begin
                cnt_d.line = v_next_i;
            end
            if (at_origin) begin
                cnt_d.pix   = '0;
                cnt_d.frame = cnt_q.frame + FRAME_W'(1);
            end else begin
                cnt_d.pix = cnt_q.pix + PIX_W'(1);
            end
            cnt_d.vb = (v_next_i >= vblank_i) && (v_next_i < vblank_end_i);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign scanline_o  = cnt_q.line;
    assign pixel_o     = cnt_q.pix;
    assign frame_o     = cnt_q.frame;
    assign in_vblank_o = cnt_q.vb;

endmodule

// File: rtl/raster_timing.sv
module raster_timing
    import raster_pkg::*;
#(
    parameter int unsigned H_W     = 12,
    parameter int unsigned V_W     = 12,
    parameter int unsigned FRAME_W = 24,
    localparam int unsigned PIX_W  = H_W + V_W
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               pix_en_i,
    input  logic [H_W-1:0]     cfg_htotal_i,
    input  logic [H_W-1:0]     cfg_hblank_i,
    input  logic [H_W-1:0]     cfg_hsync_i,
    input  logic [V_W-1:0]     cfg_vtotal_i,
    input  logic [V_W-1:0]     cfg_vblank_i,
    input  logic [V_W-1:0]     cfg_vsync_i,
    input  logic [V_W-1:0]     cfg_vblank_end_i,
    input  logic [1:0]         cfg_fs_delay_i,
    output logic [V_W-1:0]     scanline_o,
    output logic [PIX_W-1:0]   pixel_count_o,
    output logic [FRAME_W-1:0] frame_count_o,
    output logic               in_vblank_o,
    output logic               vblank_start_o,
    output logic               frame_start_o,
    output logic               vsync_start_o,
    output logic               latch_o
);

    logic              boot;
    logic              step;
    logic              latch_next;
    logic [H_W-1:0]    act_htotal, act_hblank, act_hsync;
    logic [V_W-1:0]    act_vtotal, act_vblank, act_vsync, act_vblank_end;
    logic [1:0]        act_fs_delay;
    logic [H_W-1:0]    pos_h, nxt_h;
    logic [V_W-1:0]    pos_v, nxt_v;
    logic [EV_NUM-1:0] ev;

    assign step = pix_en_i && !boot;

    raster_shadow #(.H_W(H_W), .V_W(V_W)) shadow_i (
        .clk_i            (clk_i),
        .rst_ni           (rst_ni),
        .latch_i          (latch_next),
        .cfg_htotal_i     (cfg_htotal_i),
        .cfg_hblank_i     (cfg_hblank_i),
        .cfg_hsync_i      (cfg_hsync_i),
        .cfg_vtotal_i     (cfg_vtotal_i),
        .cfg_vblank_i     (cfg_vblank_i),
        .cfg_vsync_i      (cfg_vsync_i),
        .cfg_vblank_end_i (cfg_vblank_end_i),
        .cfg_fs_delay_i   (cfg_fs_delay_i),
        .boot_o           (boot),
        .htotal_o         (act_htotal),
        .hblank_o         (act_hblank),
        .hsync_o          (act_hsync),
        .vtotal_o         (act_vtotal),
        .vblank_o         (act_vblank),
        .vsync_o          (act_vsync),
        .vblank_end_o     (act_vblank_end),
        .fs_delay_o       (act_fs_delay)
    );

    raster_position #(.H_W(H_W), .V_W(V_W)) position_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .step_i   (step),
        .htotal_i (act_htotal),
        .vtotal_i (act_vtotal),
        .h_o      (pos_h),
        .v_o      (pos_v),
        .h_next_o (nxt_h),
        .v_next_o (nxt_v)
    );

    raster_events #(.H_W(H_W), .V_W(V_W)) events_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .step_i       (step),
        .h_next_i     (nxt_h),
        .v_next_i     (nxt_v),
        .hblank_i     (act_hblank),
        .hsync_i      (act_hsync),
        .vtotal_i     (act_vtotal),
        .vblank_i     (act_vblank),
        .vsync_i      (act_vsync),
        .fs_delay_i   (act_fs_delay),
        .ev_o         (ev),
        .latch_next_o (latch_next)
    );

    raster_counters #(
        .H_W(H_W), .V_W(V_W), .PIX_W(PIX_W), .FRAME_W(FRAME_W)
    ) counters_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .step_i       (step),
        .init_i       (boot),
        .init_line_i  (cfg_vtotal_i - V_W'(1)),
        .h_next_i     (nxt_h),
        .v_next_i     (nxt_v),
        .hsync_i      (act_hsync),
        .vblank_i     (act_vblank),
        .vblank_end_i (act_vblank_end),
        .scanline_o   (scanline_o),
        .pixel_o      (pixel_count_o),
        .frame_o      (frame_count_o),
        .in_vblank_o  (in_vblank_o)
    );

    assign vblank_start_o = ev[EV_VBLANK];
    assign latch_o        = ev[EV_LATCH];
    assign frame_start_o  = ev[EV_FSTART];
    assign vsync_start_o  = ev[EV_VSYNC];

endmodule

// File: rtl/raster_timing_checker.sv
module raster_timing_checker #(
    parameter int unsigned H_W     = 12,
    parameter int unsigned V_W     = 12,
    parameter int unsigned FRAME_W = 24,
    parameter int unsigned PIX_W   = 24
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               pix_en_i,
    input logic [V_W-1:0]     scanline_i,
    input logic [PIX_W-1:0]   pixel_i,
    input logic [FRAME_W-1:0] frame_i,
    input logic               in_vblank_i,
    input logic               ev_vblank_i,
    input logic               ev_fstart_i,
    input logic               ev_vsync_i,
    input logic [H_W-1:0]     h_pos_i,
    input logic [V_W-1:0]     act_vtotal_i
);

    // R2: no pixel step without the enable
    p_pixel_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(pix_en_i) |-> $stable(pixel_i));

    // R4: frame count only moves together with the pixel counter roll-over
    p_frame_with_origin_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (frame_i != $past(frame_i)) |-> (pixel_i == '0 && frame_i == $past(frame_i) + FRAME_W'(1)));

    // R5: at the first active pixel the scanline reads one below line 0
    p_scanline_origin_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (frame_i != $past(frame_i)) |-> (scanline_i == act_vtotal_i - V_W'(1)));

    // R6: vertical-blank strobe lands on a scanline step (sync position)
    p_vblank_at_sync_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ev_vblank_i |-> (scanline_i != $past(scanline_i)));

    // R7: vertical-sync strobe lands on a scanline step
    p_vsync_at_sync_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ev_vsync_i |-> (scanline_i != $past(scanline_i)));

    // R8: frame-start strobe sits in horizontal blank, ahead of the sync step
    p_fstart_before_sync_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ev_fstart_i |-> $stable(scanline_i));

    // R9: vertical-blank level rises only at the start of a line
    p_vblank_level_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(in_vblank_i) |-> (h_pos_i == '0));

    // R11: every strobe is one clock wide
    p_vblank_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ev_vblank_i |=> !ev_vblank_i);
    p_fstart_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ev_fstart_i |=> !ev_fstart_i);
    p_vsync_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ev_vsync_i |=> !ev_vsync_i);

endmodule

bind raster_timing raster_timing_checker #(
    .H_W(H_W), .V_W(V_W), .FRAME_W(FRAME_W), .PIX_W(PIX_W)
) checker_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pix_en_i     (pix_en_i),
    .scanline_i   (scanline_o),
    .pixel_i      (pixel_count_o),
    .frame_i      (frame_count_o),
    .in_vblank_i  (in_vblank_o),
    .ev_vblank_i  (vblank_start_o),
    .ev_fstart_i  (frame_start_o),
    .ev_vsync_i   (vsync_start_o),
    .h_pos_i      (pos_h),
    .act_vtotal_i (act_vtotal)
);

// File: tb/raster_timing_tb_top.sv
module raster_timing_tb_top;

    localparam int HW = 12;
    localparam int VW = 12;
    localparam int FW = 3;
    localparam int FMOD = 1 << FW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pix_en = 1'b0;
    logic [HW-1:0] cfg_htotal = '0, cfg_hblank = '0, cfg_hsync = '0;
    logic [VW-1:0] cfg_vtotal = '0, cfg_vblank = '0, cfg_vsync = '0, cfg_vbe = '0;
    logic [1:0]    cfg_fsd = '0;

    logic [VW-1:0]    scanline;
    logic [HW+VW-1:0] pixel;
    logic [FW-1:0]    frame;
    logic in_vb, ev_vb, ev_fs, ev_vs, ev_lt;

    always #5 clk = ~clk;

    raster_timing #(.H_W(HW), .V_W(VW), .FRAME_W(FW)) dut_i (
        .clk_i            (clk),
        .rst_ni           (rst_n),
        .pix_en_i         (pix_en),
        .cfg_htotal_i     (cfg_htotal),
        .cfg_hblank_i     (cfg_hblank),
        .cfg_hsync_i      (cfg_hsync),
        .cfg_vtotal_i     (cfg_vtotal),
        .cfg_vblank_i     (cfg_vblank),
        .cfg_vsync_i      (cfg_vsync),
        .cfg_vblank_end_i (cfg_vbe),
        .cfg_fs_delay_i   (cfg_fsd),
        .scanline_o       (scanline),
        .pixel_count_o    (pixel),
        .frame_count_o    (frame),
        .in_vblank_o      (in_vb),
        .vblank_start_o   (ev_vb),
        .frame_start_o    (ev_fs),
        .vsync_start_o    (ev_vs),
        .latch_o          (ev_lt)
    );

    int n_chk = 0;
    int n_fail = 0;
    int exp_frame = 0;
    bit finished = 0;
    // active timing as the bench expects it
    int mH, mHB, mHS, mV, mVB, mVS, mVE, mD;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic set_cfg(input int h, input int hb, input int hs, input int v,
                           input int vb, input int vs, input int ve, input int d);
        cfg_htotal = HW'(h); cfg_hblank = HW'(hb); cfg_hsync = HW'(hs);
        cfg_vtotal = VW'(v); cfg_vblank = VW'(vb); cfg_vsync = VW'(vs);
        cfg_vbe = VW'(ve); cfg_fsd = 2'(d);
    endtask

    task automatic set_model(input int h, input int hb, input int hs, input int v,
                             input int vb, input int vs, input int ve, input int d);
        mH = h; mHB = hb; mHS = hs; mV = v; mVB = vb; mVS = vs; mVE = ve; mD = d;
    endtask

    // Walks one whole frame from line 0 pixel 0, comparing every output each clock.
    // gate > 1 drops the pixel enable on gate-1 of every gate clocks.
    task automatic check_frame(input int gate);
        int k = 0;
        int i = 0;
        int total = mH * mV;
        while (k < total) begin
            bit en = (i % gate) == 0;
            int p, line, hp, esl, vbl, vsl, fsl;
            bit xvb, xfs, xvs;
            string rs;
            pix_en = en;
            @(negedge clk);
            i++;
            if (en) k++;
            if (en && k == total) exp_frame = (exp_frame + 1) % FMOD;
            p = k % total;
            line = p / mH;
            hp = p % mH;
            esl = (hp >= mHS) ? line : ((line == 0) ? mV - 1 : line - 1);
            vbl = (mVB == 0) ? mV - 1 : mVB - 1;
            vsl = (mVS == 0) ? mV - 1 : mVS - 1;
            fsl = (mVB + mD) % mV;
            xvb = en && hp == mHS && line == vbl;
            xvs = en && hp == mHS && line == vsl;
            xfs = en && hp == mHB && line == fsl;
            rs = (gate > 1) ? "R2" : "R3";
            chk(rs, "pixel count", pixel, p);
            chk("R5", "scanline", scanline, esl);
            chk("R4", "frame count", frame, exp_frame);
            chk("R9", "vblank level", in_vb, (line >= mVB && line < mVE) ? 1 : 0);
            rs = (gate > 1) ? "R11" : "R6";
            chk(rs, "vblank strobe", ev_vb, xvb);
            chk("R6", "latch strobe", ev_lt, xvb);
            rs = (gate > 1) ? "R11" : "R8";
            chk(rs, "frame-start strobe", ev_fs, xfs);
            rs = (gate > 1) ? "R11" : "R7";
            chk(rs, "vsync strobe", ev_vs, xvs);
        end
        pix_en = 1'b1;
    endtask

    task automatic skip_frame();
        repeat (mH * mV) @(negedge clk);
        exp_frame = (exp_frame + 1) % FMOD;
    endtask

    task automatic t_reset();
        set_cfg(16, 10, 12, 12, 8, 9, 12, 0);
        rst_n = 1'b0;
        pix_en = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "reset pixel", pixel, 0);
        chk("R1", "reset scanline", scanline, 0);
        chk("R1", "reset frame", frame, 0);
        chk("R1", "reset strobes", {ev_vb, ev_fs, ev_vs, ev_lt, in_vb}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "load-clock pixel", pixel, 0);
        chk("R1", "load-clock scanline", scanline, 11);
        chk("R1", "load-clock frame", frame, 0);
        chk("R1", "load-clock strobes", {ev_vb, ev_fs, ev_vs, ev_lt}, 0);
        set_model(16, 10, 12, 12, 8, 9, 12, 0);
        exp_frame = 0;
    endtask

    task automatic t_base_frame();
        check_frame(1);
    endtask

    // R8 delay sweep, R9 with a shorter blank, R8 line wrap past vtotal
    task automatic t_delay_sweep();
        for (int d = 1; d <= 3; d++) begin
            int ve = (d == 2) ? 11 : 12;
            set_cfg(16, 10, 12, 12, 8, 9, ve, d);
            skip_frame();
            set_model(16, 10, 12, 12, 8, 9, ve, d);
            check_frame(1);
        end
        set_cfg(16, 10, 12, 12, 10, 11, 12, 3);
        skip_frame();
        set_model(16, 10, 12, 12, 10, 11, 12, 3);
        check_frame(1);
    endtask

    task automatic t_enable_gaps();
        check_frame(3);
    endtask

    // R10: new totals written at line 0 stay inactive until the latch strobe
    task automatic t_shadow();
        set_cfg(20, 10, 12, 13, 10, 11, 12, 3);
        for (int k = 1; k <= 224; k++) begin
            @(negedge clk);
            if (k == 155) chk("R10", "vblank strobe before old sync", ev_vb, 0);
            if (k == 156) begin
                chk("R10", "vblank strobe at old-timing sync", ev_vb, 1);
                chk("R10", "latch strobe at old-timing sync", ev_lt, 1);
            end
            if (k == 223) chk("R10", "frame before mixed roll-over", frame, exp_frame);
            if (k == 224) begin
                exp_frame = (exp_frame + 1) % FMOD;
                chk("R10", "frame at mixed roll-over", frame, exp_frame);
                chk("R10", "pixel at mixed roll-over", pixel, 0);
                chk("R10", "scanline at mixed roll-over", scanline, 12);
            end
        end
        set_model(20, 10, 12, 13, 10, 11, 12, 3);
        check_frame(1);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        t_reset();
        t_base_frame();
        t_delay_sweep();
        t_enable_gaps();
        t_shadow();
        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule